// File: doc/BRIEF.md
# Store-Intent Cache Touch Prefetch Unit

This unit sits beside the load/store pipe and takes care of the touch-for-store operation. Each cycle it may receive a decoded 32-bit instruction word together with the values of its two source registers. When the word is the touch-for-store operation, the unit forms the effective address. It presents that address on a combinational attribute lookup and, if the returned attributes allow it, asks the data cache to fetch blocks with exclusive (store) ownership. Requests leave over a valid/ready port.

The hint field selects what is fetched. One code fetches a single block. Two codes start a stream engine that walks block by block, either up or down, and stops at the edge of the current 4 KB page. Hints that only describe stream attributes are accepted and dropped. If the address is forbidden or unsuitable, the operation turns into a silent no-op: the unit never raises a fault and never writes a result.

Top module: `stpf_touch_unit`

## Requirements
- R1: A word is recognised only when bits [31:26] equal 31 and bits [10:1] equal 246 (bit 0 is the LSB). The hint is bits [25:21] and the base-register field is bits [20:16]. Bit [0] has no effect on recognition.
- R2: The effective address, driven on `lookup_addr` while the word is presented, is `rb_value + ra_value`, or just `rb_value` when the base-register field is 0.
- R3: No request is issued when the lookup reports direct-store, reports no permission, or reports caching-inhibited or guarded. No fault output exists.
- R4: Hint 5'b00000 issues exactly one request, with `req_valid` high in the cycle after the word is presented and the address aligned down to `BLOCK_BYTES`.
- R5: Hint 5'b00001 issues requests for aligned EA, +BLOCK_BYTES, +2*BLOCK_BYTES, and so on, one address per accepted handshake. Later blocks ignore the attribute inputs.
- R6: Hint 5'b00011 issues requests for aligned EA, -BLOCK_BYTES, -2*BLOCK_BYTES, and so on.
- R7: A stream issues its last request for the final block inside the `PAGE_BYTES` page that holds the EA, and then goes idle.
- R8: A pending request keeps `req_valid` high and `req_addr` stable until `req_ready` is high. At most one request completes per cycle, and no block is skipped.
- R9: Every request has `req_excl` high.
- R10: A newly accepted hint replaces any request or stream in progress. Its first block appears in the next cycle.
- R11: Hints 5'b01000, 5'b01010 and every other code not listed above issue nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction word and operands are present this cycle |
| ins_word | input | 32 | Decoded instruction word |
| ra_value | input | XLEN | Value of the base source register |
| rb_value | input | XLEN | Value of the index source register |
| lookup_addr | output | XLEN | Effective address for the attribute lookup |
| attr_direct_store | input | 1 | Lookup: address is in a direct-store segment |
| attr_permitted | input | 1 | Lookup: load access is permitted |
| attr_cache_inhibit | input | 1 | Lookup: location is caching-inhibited |
| attr_guarded | input | 1 | Lookup: location is guarded |
| req_valid | output | 1 | Prefetch request valid |
| req_ready | input | 1 | Cache accepts the request |
| req_addr | output | XLEN | Block-aligned request address |
| req_excl | output | 1 | Exclusive (store) intent flag |

## Verification
The lookup address is combinational, so the bench checks it while the word is still driven, before the clock edge. The first request is due one edge after the word, and each later stream block is due one edge after the previous handshake. The bench therefore drives and samples on the falling edge. It checks the first block in the cycle right after the issuing edge, and then one block for each cycle in which `req_ready` was high. For suppressed or dropped operations, the bench watches `req_valid` for several cycles after the word and requires it to stay low. For stream ends, it requires `req_valid` to be low in the cycle after the last block in the page is accepted.

// File: rtl/stpf_pkg.sv
package stpf_pkg;

  typedef enum logic [1:0] {
    WALK_ONE  = 2'd0,
    WALK_UP   = 2'd1,
    WALK_DOWN = 2'd2
  } walk_mode_t;

  localparam logic [5:0] PRIMARY_OP = 6'd31;
  localparam logic [9:0] EXTEND_OP  = 10'd246;

  localparam logic [4:0] HINT_ONE   = 5'b00000;
  localparam logic [4:0] HINT_UP    = 5'b00001;
  localparam logic [4:0] HINT_DOWN  = 5'b00011;

endpackage

// File: rtl/stpf_decode.sv
module stpf_decode #(
  parameter int XLEN = 64
) (
  input  logic [31:0]     word,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] index_val,
  output logic            is_touch,
  output logic [4:0]      hint,
  output logic [XLEN-1:0] eff_addr
);
  import stpf_pkg::*;

  logic [5:0] op_major;
  logic [9:0] op_minor;
  logic [4:0] base_sel;
  logic [XLEN-1:0] base_term;
  logic unused_fields;

  assign op_major = word[31:26];
  assign hint     = word[25:21];
  assign base_sel = word[20:16];
  assign op_minor = word[10:1];
  // Index field and the low bit carry no meaning here: operand value arrives ready.
  assign unused_fields = ^{word[15:11], word[0]};

  assign is_touch  = (op_major == PRIMARY_OP) && (op_minor == EXTEND_OP);
  assign base_term = (base_sel == 5'd0) ? '0 : base_val;
  assign eff_addr  = index_val + base_term;
endmodule

// File: rtl/stpf_gate.sv
module stpf_gate (
  input  logic                  ins_valid,
  input  logic                  is_touch,
  input  logic [4:0]            hint,
  input  logic                  attr_direct_store,
  input  logic                  attr_permitted,
  input  logic                  attr_cache_inhibit,
  input  logic                  attr_guarded,
  output logic                  start,
  output stpf_pkg::walk_mode_t  start_mode
);
  import stpf_pkg::*;

  logic hint_known;
  logic attr_ok;

  always_comb begin
    hint_known = 1'b1;
    start_mode = WALK_ONE;
    unique case (hint)
      HINT_ONE:  start_mode = WALK_ONE;
      HINT_UP:   start_mode = WALK_UP;
      HINT_DOWN: start_mode = WALK_DOWN;
      default:   hint_known = 1'b0;
    endcase
  end

  assign attr_ok = !attr_direct_store && attr_permitted &&
                   !attr_cache_inhibit && !attr_guarded;

  assign start = ins_valid && is_touch && hint_known && attr_ok;
endmodule

// File: rtl/stpf_walker.sv
module stpf_walker #(
  parameter int XLEN        = 64,
  parameter int BLOCK_BYTES = 128,
  parameter int PAGE_BYTES  = 4096
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  stpf_pkg::walk_mode_t start_mode,
  input  logic [XLEN-1:0]      start_addr,
  input  logic                 ready,
  output logic                 valid,
  output logic [XLEN-1:0]      addr,
  output stpf_pkg::walk_mode_t mode
);
  import stpf_pkg::*;

  localparam int BLK_LSB  = $clog2(BLOCK_BYTES);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam logic [XLEN-1:0] BLK_STEP = XLEN'(BLOCK_BYTES);

  logic [XLEN-1:0] aligned;
  logic [PAGE_LSB-BLK_LSB-1:0] slot;
  logic last_block;
  logic fire;

  assign aligned = {start_addr[XLEN-1:BLK_LSB], BLK_LSB'(0)};
  assign slot    = addr[PAGE_LSB-1:BLK_LSB];
  assign fire    = valid && ready;

  always_comb begin
    unique case (mode)
      WALK_UP:   last_block = &slot;
      WALK_DOWN: last_block = ~|slot;
      default:   last_block = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      mode  <= WALK_ONE;
    end else if (start) begin
      valid <= 1'b1;
      addr  <= aligned;
      mode  <= start_mode;
    end else if (fire) begin
      if (last_block) begin
        valid <= 1'b0;
      end else if (mode == WALK_UP) begin
        addr <= addr + BLK_STEP;
      end else begin
        addr <= addr - BLK_STEP;
      end
    end
  end
endmodule

// File: rtl/stpf_touch_unit.sv
module stpf_touch_unit #(
  parameter int XLEN        = 64,
  parameter int BLOCK_BYTES = 128,
  parameter int PAGE_BYTES  = 4096
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ins_valid,
  input  logic [31:0]     ins_word,
  input  logic [XLEN-1:0] ra_value,
  input  logic [XLEN-1:0] rb_value,
  output logic [XLEN-1:0] lookup_addr,
  input  logic            attr_direct_store,
  input  logic            attr_permitted,
  input  logic            attr_cache_inhibit,
  input  logic            attr_guarded,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [XLEN-1:0] req_addr,
  output logic            req_excl
);
  import stpf_pkg::*;

  logic            is_touch;
  logic [4:0]      hint;
  logic [XLEN-1:0] eff_addr;
  logic            start;
  walk_mode_t      start_mode;
  walk_mode_t      walk_mode;

  stpf_decode #(.XLEN(XLEN)) u_decode (
    .word      (ins_word),
    .base_val  (ra_value),
    .index_val (rb_value),
    .is_touch  (is_touch),
    .hint      (hint),
    .eff_addr  (eff_addr)
  );

  stpf_gate u_gate (
    .ins_valid          (ins_valid),
    .is_touch           (is_touch),
    .hint               (hint),
    .attr_direct_store  (attr_direct_store),
    .attr_permitted     (attr_permitted),
    .attr_cache_inhibit (attr_cache_inhibit),
    .attr_guarded       (attr_guarded),
    .start              (start),
    .start_mode         (start_mode)
  );

  stpf_walker #(
    .XLEN        (XLEN),
    .BLOCK_BYTES (BLOCK_BYTES),
    .PAGE_BYTES  (PAGE_BYTES)
  ) u_walker (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_mode (start_mode),
    .start_addr (eff_addr),
    .ready      (req_ready),
    .valid      (req_valid),
    .addr       (req_addr),
    .mode       (walk_mode)
  );

  assign lookup_addr = eff_addr;
  assign req_excl    = 1'b1;
endmodule

// File: rtl/stpf_touch_unit_chk.sv
module stpf_touch_unit_chk #(
  parameter int XLEN        = 64,
  parameter int BLOCK_BYTES = 128,
  parameter int PAGE_BYTES  = 4096
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ins_valid,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [XLEN-1:0]      req_addr,
  input logic                 req_excl,
  input stpf_pkg::walk_mode_t walk_mode
);
  import stpf_pkg::*;

  localparam int BLK_LSB  = $clog2(BLOCK_BYTES);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam logic [XLEN-1:0] BLK_STEP = XLEN'(BLOCK_BYTES);

  assert_hold_until_ready_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !ins_valid) |=> (req_valid && $stable(req_addr)));

  assert_excl_intent_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_excl);

  assert_block_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_addr[BLK_LSB-1:0] == '0));

  assert_up_step_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !ins_valid && walk_mode == WALK_UP) |=>
    (!req_valid || req_addr == $past(req_addr) + BLK_STEP));

  assert_down_step_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !ins_valid && walk_mode == WALK_DOWN) |=>
    (!req_valid || req_addr == $past(req_addr) - BLK_STEP));

  assert_same_page_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !ins_valid) |=>
    (!req_valid || req_addr[XLEN-1:PAGE_LSB] == $past(req_addr[XLEN-1:PAGE_LSB])));

  assert_single_done_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !ins_valid && walk_mode == WALK_ONE) |=> !req_valid);

  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && !ins_valid) |=> !req_valid);
endmodule

bind stpf_touch_unit stpf_touch_unit_chk #(
  .XLEN        (XLEN),
  .BLOCK_BYTES (BLOCK_BYTES),
  .PAGE_BYTES  (PAGE_BYTES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ins_valid (ins_valid),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_excl  (req_excl),
  .walk_mode (walk_mode)
);

// File: tb/tb_stpf_touch_unit.sv
module tb_stpf_touch_unit;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;
  localparam int BLK  = 128;
  localparam int WATCHDOG_CYCLES = 20000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            ins_valid = 1'b0;
  logic [31:0]     ins_word = '0;
  logic [XLEN-1:0] ra_value = '0;
  logic [XLEN-1:0] rb_value = '0;
  logic [XLEN-1:0] lookup_addr;
  logic            attr_direct_store = 1'b0;
  logic            attr_permitted = 1'b1;
  logic            attr_cache_inhibit = 1'b0;
  logic            attr_guarded = 1'b0;
  logic            req_valid;
  logic            req_ready = 1'b1;
  logic [XLEN-1:0] req_addr;
  logic            req_excl;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stpf_touch_unit #(.XLEN(XLEN), .BLOCK_BYTES(BLK), .PAGE_BYTES(4096)) dut (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_word(ins_word),
    .ra_value(ra_value), .rb_value(rb_value), .lookup_addr(lookup_addr),
    .attr_direct_store(attr_direct_store), .attr_permitted(attr_permitted),
    .attr_cache_inhibit(attr_cache_inhibit), .attr_guarded(attr_guarded),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_excl(req_excl)
  );

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] th,
                                     input logic [4:0] raf, input logic [9:0] xo,
                                     input logic low);
    return {op, th, raf, 5'd7, xo, low};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Caller is at a falling edge; word is driven for one cycle.
  task automatic issue(input logic [31:0] w, input logic [XLEN-1:0] ra,
                       input logic [XLEN-1:0] rb, input logic [3:0] attrs);
    ins_word = w; ra_value = ra; rb_value = rb; ins_valid = 1'b1;
    {attr_direct_store, attr_permitted, attr_cache_inhibit, attr_guarded} = attrs;
    @(posedge clk);
    @(negedge clk);
    ins_valid = 1'b0;
    {attr_direct_store, attr_permitted, attr_cache_inhibit, attr_guarded} = 4'b0100;
  endtask

  task automatic expect_seq(input logic [XLEN-1:0] first, input logic up, input int n,
                            input string tag);
    for (int i = 0; i < n; i++) begin
      logic [XLEN-1:0] e;
      e = up ? first + XLEN'(i*BLK) : first - XLEN'(i*BLK);
      chk(req_valid && req_addr == e && req_excl, tag, req_addr, e);
      @(negedge clk);
    end
    chk(!req_valid, {tag, " end"}, {63'd0, req_valid}, '0);
  endtask

  task automatic expect_none(input string tag);
    for (int i = 0; i < 4; i++) begin
      chk(!req_valid, tag, {63'd0, req_valid}, '0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(!req_valid, "R8 reset idle", {63'd0, req_valid}, '0);
  endtask

  task automatic t_single;
    req_ready = 1'b1;
    ins_word = mk(6'd31, 5'd0, 5'd3, 10'd246, 1'b0);
    ra_value = 64'h1000; rb_value = 64'h0234; ins_valid = 1'b1;
    #1 chk(lookup_addr == 64'h1234, "R2 ea sum", lookup_addr, 64'h1234);
    @(posedge clk); @(negedge clk); ins_valid = 1'b0;
    chk(req_valid && req_addr == 64'h1200, "R4 single block", req_addr, 64'h1200);
    chk(req_excl, "R9 excl", {63'd0, req_excl}, 64'd1);
    @(negedge clk);
    chk(!req_valid, "R4 only one", {63'd0, req_valid}, '0);
  endtask

  task automatic t_ra_zero;
    ins_word = mk(6'd31, 5'd0, 5'd0, 10'd246, 1'b0);
    ra_value = 64'hFFFF_0000_0000; rb_value = 64'h5_0080; ins_valid = 1'b1;
    #1 chk(lookup_addr == 64'h5_0080, "R2 ra field zero", lookup_addr, 64'h5_0080);
    @(posedge clk); @(negedge clk); ins_valid = 1'b0;
    expect_seq(64'h5_0080, 1'b1, 1, "R2 ra zero request");
  endtask

  task automatic t_hold;
    req_ready = 1'b0;
    issue(mk(6'd31, 5'd0, 5'd1, 10'd246, 1'b0), 64'h100, 64'h7F, 4'b0100);
    for (int i = 0; i < 3; i++) begin
      chk(req_valid && req_addr == 64'h100, "R8 hold", req_addr, 64'h100);
      @(negedge clk);
    end
    req_ready = 1'b1;
    @(negedge clk);
    chk(!req_valid, "R8 released", {63'd0, req_valid}, '0);
  endtask

  task automatic t_up;
    issue(mk(6'd31, 5'd1, 5'd2, 10'd246, 1'b0), 64'h1D00, 64'h5, 4'b0100);
    attr_guarded = 1'b1; // later blocks must ignore attributes
    expect_seq(64'h1D00, 1'b1, 6, "R5 R7 ascending");
    attr_guarded = 1'b0;
  endtask

  task automatic t_down;
    issue(mk(6'd31, 5'd3, 5'd2, 10'd246, 1'b0), 64'h2180, 64'h3, 4'b0100);
    expect_seq(64'h2180, 1'b0, 4, "R6 R7 descending");
  endtask

  task automatic t_ready_toggle;
    logic [XLEN-1:0] e;
    int got;
    e = 64'h3E00; got = 0;
    issue(mk(6'd31, 5'd1, 5'd0, 10'd246, 1'b0), 64'h0, 64'h3E40, 4'b0100);
    for (int c = 0; c < 12; c++) begin
      req_ready = c[0];
      if (req_valid) begin
        chk(req_addr == e, "R8 no skip", req_addr, e);
        if (req_ready) begin e = e + XLEN'(BLK); got++; end
      end
      @(negedge clk);
    end
    req_ready = 1'b1;
    chk(got == 4, "R7 R8 accepted count", XLEN'(got), 64'd4);
    chk(!req_valid, "R7 toggle end", {63'd0, req_valid}, '0);
  endtask

  task automatic t_attrs;
    issue(mk(6'd31, 5'd0, 5'd1, 10'd246, 1'b0), 64'h0, 64'h4000, 4'b1100);
    expect_none("R3 direct store");
    issue(mk(6'd31, 5'd1, 5'd1, 10'd246, 1'b0), 64'h0, 64'h4000, 4'b0000);
    expect_none("R3 not permitted");
    issue(mk(6'd31, 5'd0, 5'd1, 10'd246, 1'b0), 64'h0, 64'h4000, 4'b0110);
    expect_none("R3 inhibited");
    issue(mk(6'd31, 5'd3, 5'd1, 10'd246, 1'b0), 64'h0, 64'h4000, 4'b0101);
    expect_none("R3 guarded");
  endtask

  task automatic t_hints;
    issue(mk(6'd31, 5'b01000, 5'd1, 10'd246, 1'b0), 64'h0, 64'h8000, 4'b0100);
    expect_none("R11 descriptor 01000");
    issue(mk(6'd31, 5'b01010, 5'd1, 10'd246, 1'b0), 64'h0, 64'h8000, 4'b0100);
    expect_none("R11 descriptor 01010");
    issue(mk(6'd31, 5'b00010, 5'd1, 10'd246, 1'b0), 64'h0, 64'h8000, 4'b0100);
    expect_none("R11 unlisted 00010");
  endtask

  task automatic t_decode;
    issue(mk(6'd30, 5'd0, 5'd1, 10'd246, 1'b0), 64'h0, 64'h9000, 4'b0100);
    expect_none("R1 wrong primary");
    issue(mk(6'd31, 5'd0, 5'd1, 10'd247, 1'b0), 64'h0, 64'h9000, 4'b0100);
    expect_none("R1 wrong extended");
    issue(mk(6'd31, 5'd0, 5'd1, 10'd246, 1'b1), 64'h0, 64'h9000, 4'b0100);
    expect_seq(64'h9000, 1'b1, 1, "R1 low bit ignored");
  endtask

  task automatic t_replace;
    issue(mk(6'd31, 5'd1, 5'd0, 10'd246, 1'b0), 64'h0, 64'h10000, 4'b0100);
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk(req_valid && req_addr == 64'h10180, "R10 old stream running", req_addr, 64'h10180);
    issue(mk(6'd31, 5'd3, 5'd0, 10'd246, 1'b0), 64'h0, 64'h20110, 4'b0100);
    expect_seq(64'h20100, 1'b0, 3, "R10 replaced stream");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset;
    rst = 1'b0;
    @(negedge clk);
    t_single;
    t_ra_zero;
    t_hold;
    t_up;
    t_down;
    t_ready_toggle;
    t_attrs;
    t_hints;
    t_decode;
    t_replace;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule